// File: doc/BRIEF.md
# Watchdog Timer with Feed Sequence

This block supervises software with a free-running 12-bit prescaler and an 8-bit down counter. The counter steps down once per period of a prescaler tap that software picks, so each count lasts 32, 64, ... or 4096 source ticks. Software must write a two-byte key to the feed address before the counter runs past zero. If it fails, and watchdog mode is on, the block pulses a system reset request. With watchdog mode off, the same hardware serves as an interval timer and raises a sticky interrupt at each underflow. After each underflow the counter reloads by itself.

The count source is chosen by a select input: the peripheral clock, or one of two slower oscillators. Each slow oscillator arrives as a one-cycle enable on the peripheral clock domain. Once watchdog mode is turned on, the configuration is locked, and only the power-on reset unlocks it. A counter value output lets the surrounding logic and the test bench watch progress.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset, rst_req_o and irq_o are 0, count_o is 0xFF and the control register is cleared (run off, watchdog mode off, tap 0, unlocked).
- R2: With run (control bit 0) set and the peripheral clock selected, count_o decrements once every 32·2^n clocks, where n is control bits 4:2. The first decrement comes 32·2^n clocks after a feed.
- R3: In watchdog mode (control bit 1 = 1), a decrement from 0 drives rst_req_o high for exactly one cycle and reloads count_o from the reload register (address 1).
- R4: A write of 0xA5 to the feed address (2), directly followed by a write of 0x5A to the feed address, reloads count_o from the reload register on that second write. It also restarts the prescaler, and it does so even when run is off.
- R5: A 0x5A feed write whose preceding write was not 0xA5 to the feed address (another address, another value, or no 0xA5 at all) leaves count_o unchanged.
- R6: In timer mode (control bit 1 = 0), a decrement from 0 sets irq_o and reloads the counter, with no reset request. irq_o stays high until a control write with bit 5 = 1 clears it.
- R7: A control write with bit 1 = 1 sets a lock. While the lock is set, control and reload writes do not change the configuration, while feeds still work. Only rst_ni clears the lock.
- R8: clk_sel_i selects the count source: 0 peripheral clock, 1 lfo_tick_i, 2 xtal_tick_i, 3 none. Enables from a source that is not selected have no effect.
- R9: With clk_sel_i = 0 and cpu_pd_i = 1, counting stops and no reset request is made. A slow oscillator source keeps counting while cpu_pd_i = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 reload, 2 feed |
| wr_data_i | input | 8 | Write data |
| clk_sel_i | input | 2 | Count source select |
| lfo_tick_i | input | 1 | Low-frequency oscillator enable |
| xtal_tick_i | input | 1 | Crystal oscillator enable |
| cpu_pd_i | input | 1 | CPU power-down indication |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Sticky interval-timer interrupt |
| count_o | output | 8 | Current down-counter value |

## Verification
The bench measures the exact underflow cycle at two tap settings. An off-by-one in the tap decode, or a prescaler that is not cleared by the feed, would move the reset pulse by a whole tap period or by a fraction of one. It feeds a stopped counter with broken key sequences, so a sequencer that remembered 0xA5 across a foreign write would reload when it should not. It tries to rewrite a locked configuration, and a weak lock would let the counter start or pick up the new reload value. It also runs the counter from unselected sources and during power-down, where a wrong source mux would count or fire a reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_RELOAD = 2'd1,
    ADDR_FEED   = 2'd2,
    ADDR_NONE   = 2'd3
  } wdog_addr_e;

  typedef enum logic [1:0] {
    SRC_PCLK = 2'd0,
    SRC_LFO  = 2'd1,
    SRC_XTAL = 2'd2,
    SRC_OFF  = 2'd3
  } wdog_src_e;

  localparam logic [7:0] FEED_KEY_A = 8'hA5;
  localparam logic [7:0] FEED_KEY_B = 8'h5A;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_WD_BIT  = 1;
  localparam int CTRL_TAP_LSB = 2;
  localparam int CTRL_CLR_BIT = 5;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRESC_W  = 12,
  parameter int TAP_W    = 3,
  parameter int TAP_MIN  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             dec_o
);
  localparam int NTAPS = 1 << TAP_W;

  logic [PRESC_W-1:0] presc_q;
  logic [NTAPS-1:0]   wrap;

  // tap g wraps every 2^(TAP_MIN+g) ticks
  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    assign wrap[g] = &presc_q[TAP_MIN+g-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     presc_q <= '0;
    else if (clr_i)  presc_q <= '0;
    else if (tick_i) presc_q <= presc_q + 1'b1;
  end

  assign dec_o = tick_i & ~clr_i & wrap[tap_i];
endmodule

// File: rtl/wdog_feed_seq.sv
module wdog_feed_seq
  import wdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic       feed_o
);
  logic armed_q;
  logic at_feed;

  assign at_feed = (wr_addr_i == ADDR_FEED);

  // any write re-evaluates the arm; only a first key leaves it set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (wr_en_i) armed_q <= at_feed && (wr_data_i == FEED_KEY_A);
  end

  assign feed_o = wr_en_i & at_feed & armed_q & (wr_data_i == FEED_KEY_B);
endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uflow_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '1;
    else if (load_i) cnt_q <= reload_i;
    else if (dec_i)  cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
  end

  assign uflow_o = dec_i & ~load_i & (cnt_q == '0);
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int PRESC_W = 12,
  parameter int CNT_W   = 8,
  parameter int TAP_W   = 3,
  parameter int TAP_MIN = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic [1:0]       clk_sel_i,
  input  logic             lfo_tick_i,
  input  logic             xtal_tick_i,
  input  logic             cpu_pd_i,
  output logic             rst_req_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int NTAPS = 1 << TAP_W;
  localparam logic [CNT_W-1:0] RELOAD_RST = '1;

  initial begin
    if (PRESC_W < TAP_MIN + NTAPS - 1) $error("prescaler too narrow for tap set");
    if (CNT_W > 8) $error("counter wider than write data");
  end

  logic             run_q, wd_mode_q, lock_q, irq_q, rst_req_q;
  logic [TAP_W-1:0] tap_q;
  logic [CNT_W-1:0] reload_q;
  logic             tick, dec, feed, uflow;
  logic             wr_ctrl, wr_reload;

  assign wr_ctrl   = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_reload = wr_en_i && (wr_addr_i == ADDR_RELOAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      wd_mode_q <= 1'b0;
      tap_q     <= '0;
      lock_q    <= 1'b0;
      reload_q  <= RELOAD_RST;
    end else begin
      if (wr_ctrl && !lock_q) begin
        run_q     <= wr_data_i[CTRL_RUN_BIT];
        wd_mode_q <= wr_data_i[CTRL_WD_BIT];
        tap_q     <= wr_data_i[CTRL_TAP_LSB +: TAP_W];
        lock_q    <= wr_data_i[CTRL_WD_BIT];
      end
      if (wr_reload && !lock_q) reload_q <= wr_data_i[CNT_W-1:0];
    end
  end

  always_comb begin
    unique case (wdog_src_e'(clk_sel_i))
      SRC_PCLK: tick = ~cpu_pd_i;
      SRC_LFO:  tick = lfo_tick_i;
      SRC_XTAL: tick = xtal_tick_i;
      default:  tick = 1'b0;
    endcase
    tick = tick & run_q;
  end

  wdog_prescaler #(
    .PRESC_W (PRESC_W),
    .TAP_W   (TAP_W),
    .TAP_MIN (TAP_MIN)
  ) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .clr_i  (feed),
    .tap_i  (tap_q),
    .dec_o  (dec)
  );

  wdog_feed_seq u_feed (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .feed_o    (feed)
  );

  wdog_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dec_i    (dec),
    .load_i   (feed),
    .reload_i (reload_q),
    .cnt_o    (count_o),
    .uflow_o  (uflow)
  );

  // set wins over a same-cycle clear so no underflow is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= uflow & wd_mode_q;
      if (uflow && !wd_mode_q)                   irq_q <= 1'b1;
      else if (wr_ctrl && wr_data_i[CTRL_CLR_BIT]) irq_q <= 1'b0;
    end
  end

  assign rst_req_o = rst_req_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic [7:0]       wr_data_i,
  input logic [1:0]       clk_sel_i,
  input logic             cpu_pd_i,
  input logic             rst_req_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] count_o,
  input logic             wd_mode_q,
  input logic             lock_q,
  input logic [CNT_W-1:0] reload_q
);
  logic irq_clr_wr;
  assign irq_clr_wr = wr_en_i && (wr_addr_i == 2'd0) && wr_data_i[5];

  assert_req_needs_wd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(wd_mode_q));

  assert_req_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  assert_irq_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_wr) |=> irq_o);

  assert_irq_timer_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !$past(wd_mode_q));

  assert_lock_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);

  assert_lock_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(reload_q));

  assert_pd_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_pd_i && clk_sel_i == 2'd0 && !wr_en_i) |=> $stable(count_o));
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .clk_sel_i (clk_sel_i),
  .cpu_pd_i  (cpu_pd_i),
  .rst_req_o (rst_req_o),
  .irq_o     (irq_o),
  .count_o   (count_o),
  .wd_mode_q (wd_mode_q),
  .lock_q    (lock_q),
  .reload_q  (reload_q)
);

// File: tb/wdog_timer_tb_top.sv
module wdog_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 50000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] clk_sel = 2'd0;
  logic       lfo = 1'b0;
  logic       xtal = 1'b0;
  logic       pd = 1'b0;
  logic       rst_req;
  logic       irq;
  logic [7:0] cnt;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .clk_sel_i   (clk_sel),
    .lfo_tick_i  (lfo),
    .xtal_tick_i (xtal),
    .cpu_pd_i    (pd),
    .rst_req_o   (rst_req),
    .irq_o       (irq),
    .count_o     (cnt)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic por();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; clk_sel = 2'd0; lfo = 1'b0; xtal = 1'b0; pd = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic feed();
    wr(2'd2, 8'hA5);
    wr(2'd2, 8'h5A);
  endtask

  task automatic t_reset();
    por();
    check("R1", "rst_req", rst_req, 0);
    check("R1", "irq", irq, 0);
    check("R1", "count", cnt, 8'hFF);
    idle(40);  // run off after reset: no counting
    check("R1", "count idle", cnt, 8'hFF);
  endtask

  task automatic t_wd_period();
    por();
    wr(2'd1, 8'd2);
    wr(2'd0, 8'h03);  // run, watchdog, tap 0
    feed();
    check("R4", "count after feed", cnt, 2);
    idle(31);
    check("R2", "count before first step", cnt, 2);
    idle(1);
    check("R2", "count after 32", cnt, 1);
    idle(63);
    check("R3", "count at zero", cnt, 0);
    check("R3", "no early reset", rst_req, 0);
    idle(1);
    check("R3", "reset request", rst_req, 1);
    check("R3", "reload on underflow", cnt, 2);
    idle(1);
    check("R3", "reset pulse width", rst_req, 0);
    check("R3", "no irq in wd mode", irq, 0);
  endtask

  task automatic t_timer_irq();
    por();
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h09);  // run, timer, tap 2 (128)
    feed();
    idle(127);
    check("R2", "irq before 128", irq, 0);
    idle(1);
    check("R6", "irq at underflow", irq, 1);
    check("R6", "no reset in timer mode", rst_req, 0);
    idle(50);
    check("R6", "irq sticky", irq, 1);
    wr(2'd0, 8'h29);
    check("R6", "irq cleared", irq, 0);
  endtask

  task automatic t_feed_abort();
    por();
    wr(2'd1, 8'h33);
    wr(2'd0, 8'h00);  // stopped, timer mode
    feed();
    check("R4", "feed while stopped", cnt, 8'h33);
    wr(2'd1, 8'h44);
    wr(2'd2, 8'h5A);
    check("R5", "second key alone", cnt, 8'h33);
    wr(2'd2, 8'hA5);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h5A);
    check("R5", "foreign write between", cnt, 8'h33);
    wr(2'd2, 8'hA5);
    wr(2'd2, 8'h5B);
    wr(2'd2, 8'h5A);
    check("R5", "wrong value between", cnt, 8'h33);
    feed();
    check("R4", "good feed after aborts", cnt, 8'h44);
  endtask

  task automatic t_lock();
    por();
    wr(2'd1, 8'h20);
    wr(2'd0, 8'h02);  // watchdog mode, stopped -> lock
    wr(2'd1, 8'h70);
    wr(2'd0, 8'h01);
    feed();
    check("R7", "reload kept under lock", cnt, 8'h20);
    idle(40);
    check("R7", "run write ignored under lock", cnt, 8'h20);
    por();
    check("R1", "count after re-POR", cnt, 8'hFF);
    wr(2'd1, 8'h70);
    feed();
    check("R7", "reload writable after POR", cnt, 8'h70);
  endtask

  task automatic t_clk_sel();
    por();
    wr(2'd1, 8'd1);
    wr(2'd0, 8'h01);
    @(negedge clk) clk_sel = 2'd1;
    feed();
    idle(100);
    check("R8", "lfo idle", cnt, 1);
    lfo = 1'b1;
    idle(32);
    lfo = 1'b0;
    check("R8", "lfo 32 ticks", cnt, 0);
    clk_sel = 2'd2;
    lfo = 1'b1;
    idle(100);
    lfo = 1'b0;
    check("R8", "lfo ignored on xtal", cnt, 0);
    check("R8", "no irq yet", irq, 0);
    xtal = 1'b1;
    idle(32);
    xtal = 1'b0;
    check("R8", "xtal underflow irq", irq, 1);
    check("R8", "xtal reload", cnt, 1);
    clk_sel = 2'd3;
    idle(100);
    check("R8", "no source", cnt, 1);
  endtask

  task automatic t_pd();
    int seen;
    por();
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h03);
    feed();
    pd = 1'b1;
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rst_req) seen++;
    end
    check("R9", "no reset in pd", seen, 0);
    check("R9", "count frozen", cnt, 0);
    clk_sel = 2'd1;
    lfo = 1'b1;
    idle(31);
    check("R9", "lfo in pd before", rst_req, 0);
    idle(1);
    check("R9", "lfo in pd reset", rst_req, 1);
    lfo = 1'b0;
  endtask

  initial begin
    t_reset();
    t_wd_period();
    t_timer_irq();
    t_feed_abort();
    t_lock();
    t_clk_sel();
    t_pd();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WDOG_LIMIT) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule